// File: doc/BRIEF.md
# Hybrid Cellular Automaton Pattern Generator

This block produces pseudo-random test stimulus from a one-dimensional row of cells. Each cell's next value depends on itself and on its immediate neighbours. A cell either ignores its own state (rule 90) or includes it (rule 150). The cells at the two ends of the row see a constant 0 in place of the missing neighbour. The mix of rules is fixed at elaboration by a bit vector parameter, with one bit per cell. Because every cell looks at both of its neighbours, the spread of values across the row differs from a shift register with a single feedback path.

In use, the generator is loaded with a seed and then stepped by an enable. Each step presents a new parallel word on the pattern output. The all-zero state would lock the row forever, so a seed of zero is replaced by a word with only cell 0 set. The default configuration has four cells. From a seed with only cell 3 set, it walks through all 15 nonzero states before it returns to that seed.

Top module: `ca_pattern_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the pattern becomes 1 (only cell 0 set) at that edge. Reset takes priority over seed load and enable.
- R2: A rule-90 cell takes, at each step, the XOR of its left and right neighbours' current values.
- R3: A rule-150 cell takes, at each step, the XOR of its left neighbour, its own value and its right neighbour.
- R4: The left neighbour of cell 0 and the right neighbour of cell CELLS-1 are constant 0.
- R5: Bit i of parameter `RULE_MAP` selects the rule of cell i: 1 means rule 150 and 0 means rule 90. The default for 4 cells is 4'b0101, which gives cells 0 to 3 the rules 150, 90, 150, 90.
- R6: Pattern bit i is the state of cell i. Each result appears at the rising edge where it is requested. With the defaults, stepping from 4'h8 yields in hex 8, 4, E, F, C, A, 1, 3, 6, B, 2, 5, D, 9, 7, and then 8 again.
- R7: With the defaults, every nonzero state returns to itself after exactly 15 steps, and no state repeats before then.
- R8: When `seedLoad` is high, the pattern becomes `seedValue` at that edge, whatever the value of `enable`.
- R9: A seed load with `seedValue` equal to 0 sets the pattern to 1 instead, so the pattern is never zero.
- R10: When `enable` and `seedLoad` are both low, the pattern holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| seedLoad | input | 1 | Load `seedValue` into the cells this edge |
| seedValue | input | CELLS | Seed word; bit i goes to cell i |
| enable | input | 1 | Advance the automaton one step this edge |
| pattern | output | CELLS | Current cell states; bit i is cell i |

## Verification
Every result of this block is due exactly one rising edge after its stimulus:
- a reset, a seed load or a step becomes visible on `pattern` at that edge;
- a hold shows the same word after the edge.

The bench changes inputs only just after it samples, 2 ns past a rising edge. It then waits one full edge before it compares the next value. It sweeps every nonzero seed, follows each orbit for 15 steps, and checks each word against a neighbour-rule model written from the requirements. It also compares the default run from 4'h8 with the listed sequence.

// File: rtl/ca_pkg.sv
package ca_pkg;

  // Strobes from the control to the cell array
  typedef struct packed {
    logic loadSeed;  // overwrite the cells with the load word
    logic step;      // advance all cells one generation
  } caStrobe_t;

endpackage

// File: rtl/ca_ctrl.sv
module ca_ctrl
  import ca_pkg::*;
#(
  parameter int CELLS = 4
) (
  input  logic             seedLoad,
  input  logic             enable,
  input  logic [CELLS-1:0] seedValue,
  output caStrobe_t        strobe,
  output logic [CELLS-1:0] loadWord
);

  localparam logic [CELLS-1:0] SAFE_SEED = CELLS'(1);

  logic seedIsZero;

  assign seedIsZero = (seedValue == '0);

  // Seed load wins over stepping
  always_comb begin
    strobe.loadSeed = seedLoad;
    strobe.step     = enable & ~seedLoad;
  end

  // A zero seed would lock up the automaton
  assign loadWord = seedIsZero ? SAFE_SEED : seedValue;

endmodule

// File: rtl/ca_cells.sv
module ca_cells
  import ca_pkg::*;
#(
  parameter int               CELLS    = 4,
  parameter logic [CELLS-1:0] RULE_MAP = 4'b0101
) (
  input  logic             clk,
  input  logic             rst,
  input  caStrobe_t        strobe,
  input  logic [CELLS-1:0] loadWord,
  output logic [CELLS-1:0] state
);

  localparam logic [CELLS-1:0] RESET_WORD = CELLS'(1);

  logic [CELLS-1:0] nextGen;
  logic [CELLS-1:0] leftIn;
  logic [CELLS-1:0] rightIn;

  // Neighbour wiring with null boundaries
  for (genvar i = 0; i < CELLS; i++) begin : g_nbr
    if (i == 0) begin : g_leftEdge
      assign leftIn[i] = 1'b0;
    end else begin : g_leftInner
      assign leftIn[i] = state[i-1];
    end
    if (i == CELLS - 1) begin : g_rightEdge
      assign rightIn[i] = 1'b0;
    end else begin : g_rightInner
      assign rightIn[i] = state[i+1];
    end
  end

  // Per-cell rule chosen at elaboration
  for (genvar i = 0; i < CELLS; i++) begin : g_rule
    if (RULE_MAP[i]) begin : g_r150
      assign nextGen[i] = leftIn[i] ^ state[i] ^ rightIn[i];
    end else begin : g_r90
      assign nextGen[i] = leftIn[i] ^ rightIn[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RESET_WORD;
    end else if (strobe.loadSeed) begin
      state <= loadWord;
    end else if (strobe.step) begin
      state <= nextGen;
    end
  end

endmodule

// File: rtl/ca_pattern_gen.sv
module ca_pattern_gen
  import ca_pkg::*;
#(
  parameter int               CELLS    = 4,
  parameter logic [CELLS-1:0] RULE_MAP = 4'b0101
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seedLoad,
  input  logic [CELLS-1:0] seedValue,
  input  logic             enable,
  output logic [CELLS-1:0] pattern
);

  caStrobe_t        strobe;
  logic [CELLS-1:0] loadWord;

  ca_ctrl #(.CELLS(CELLS)) uCtrl (
    .seedLoad (seedLoad),
    .enable   (enable),
    .seedValue(seedValue),
    .strobe   (strobe),
    .loadWord (loadWord)
  );

  ca_cells #(.CELLS(CELLS), .RULE_MAP(RULE_MAP)) uCells (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .loadWord(loadWord),
    .state   (pattern)
  );

endmodule

// File: rtl/ca_pattern_gen_chk.sv
module ca_pattern_gen_chk #(
  parameter int CELLS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             seedLoad,
  input logic [CELLS-1:0] seedValue,
  input logic             enable,
  input logic [CELLS-1:0] pattern
);

  // R1
  reset_word_chk: assert property (@(posedge clk)
    rst |=> pattern == CELLS'(1));

  // R8
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && seedValue != '0) |=> pattern == $past(seedValue));

  // R9
  zero_seed_chk: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && seedValue == '0) |=> pattern == CELLS'(1));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!seedLoad && !enable) |=> $stable(pattern));

  // R9
  never_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) == 1'b0 |-> pattern != '0);

endmodule

bind ca_pattern_gen ca_pattern_gen_chk #(.CELLS(CELLS)) uChk (
  .clk      (clk),
  .rst      (rst),
  .seedLoad (seedLoad),
  .seedValue(seedValue),
  .enable   (enable),
  .pattern  (pattern)
);

// File: tb/tb_ca_pattern_gen.sv
module tb_ca_pattern_gen;

  localparam int N = 4;
  localparam logic [N-1:0] RULES = 4'b0101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seedLoad = 1'b0;
  logic [N-1:0] seedValue = '0;
  logic enable = 1'b0;
  logic [N-1:0] pattern;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ca_pattern_gen #(.CELLS(N), .RULE_MAP(RULES)) dut (
    .clk(clk), .rst(rst), .seedLoad(seedLoad),
    .seedValue(seedValue), .enable(enable), .pattern(pattern)
  );

  // Neighbour-rule model taken from R2..R5
  function automatic logic [N-1:0] model(input logic [N-1:0] s);
    logic [N-1:0] n;
    for (int i = 0; i < N; i++) begin
      logic l, r;
      l = (i > 0) ? s[i-1] : 1'b0;
      r = (i < N-1) ? s[i+1] : 1'b0;
      n[i] = l ^ r ^ (RULES[i] ? s[i] : 1'b0);
    end
    return n;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] got,
                       input logic [N-1:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  logic [N-1:0] refSeq [15] = '{4'h8, 4'h4, 4'hE, 4'hF, 4'hC, 4'hA, 4'h1,
                                4'h3, 4'h6, 4'hB, 4'h2, 4'h5, 4'hD, 4'h9, 4'h7};

  initial begin
    logic [N-1:0] prev;
    logic [15:0] seen;
    // R1: reset state
    tick(); tick();
    check("R1 reset", pattern, 4'h1);
    rst = 1'b0;

    // R8: load seed 8
    seedLoad = 1'b1; seedValue = 4'h8;
    tick();
    seedLoad = 1'b0;
    check("R8 load", pattern, 4'h8);

    // R6: known default sequence
    enable = 1'b1;
    for (int k = 1; k <= 15; k++) begin
      tick();
      check("R6 sequence", pattern, refSeq[k % 15]);
    end

    // R10: hold with enable low
    enable = 1'b0;
    prev = pattern;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R10 hold", pattern, prev);
    end

    // R8: load priority over enable
    enable = 1'b1; seedLoad = 1'b1; seedValue = 4'h5;
    tick();
    check("R8 priority", pattern, 4'h5);

    // R9: zero seed replaced by 1
    seedValue = 4'h0;
    tick();
    check("R9 zero seed", pattern, 4'h1);
    seedLoad = 1'b0; enable = 1'b0;

    // R2 R3 R4 R7: sweep every nonzero seed and follow its orbit
    for (int s = 1; s < 16; s++) begin
      seedLoad = 1'b1; seedValue = N'(s);
      tick();
      seedLoad = 1'b0; enable = 1'b1;
      check("R8 sweep load", pattern, N'(s));
      seen = '0;
      seen[s] = 1'b1;
      for (int k = 1; k <= 15; k++) begin
        prev = pattern;
        tick();
        check("R2/R3/R4 step", pattern, model(prev));
        if (k < 15) begin
          vectors++;
          if (seen[pattern]) begin
            miscompares++;
            $display("FAIL R7 early repeat: got %h expected unseen state", pattern);
          end
          seen[pattern] = 1'b1;
        end
      end
      check("R7 period 15", pattern, N'(s));
      enable = 1'b0;
    end

    // R1: reset wins over seed load
    seedLoad = 1'b1; seedValue = 4'hC; rst = 1'b1;
    tick();
    check("R1 reset priority", pattern, 4'h1);
    rst = 1'b0; seedLoad = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule